// File: doc/BRIEF.md
# Inbound DMA Window Translator

This block sits between the bus-master side of a PCI host bridge and local memory. Every address a bus master presents is compared against three programmable inbound windows. Each window has a 64-bit size/attribute word and a 64-bit local base. A hit rebases the address into local memory. When no enabled window matches, the address is returned unchanged so that it is treated as ordinary PCI bus memory.

Software programs the windows through a 32-bit register port. Each access carries a byte offset and moves one 32-bit word. Window 1 has only a single 32-bit size word. The other two windows split their size word across a low register and a high register.

The lookup path is a single registered stage. An address presented with `bm_valid` produces a result on `xl_*` in the next cycle. A second input, `bm_claimed`, marks addresses that the direct bus-memory view already owns. Inbound windows rank below that view, so a claimed address is never redirected.

Top module: `inb_dma_xlate`

## Requirements
- R1: After reset, every window's size word reads as 0xFFFFFFFF_00000000, every local base reads as zero, the status word reads as zero, and every lookup misses.
- R2: Register offsets (byte, 32-bit words) are as follows. Window 0: size low 0x98, size high 0xF8, base low 0x9C, base high 0xA0. Window 1: size 0xA4, base low 0xA8, base high 0xAC. Window 2: size low 0xB0, size high 0xFC, base low 0xB4, base high 0xB8. Status: 0xE0. A read from any other offset returns zero, and a write to any other offset changes nothing.
- R3: For windows 0 and 2, writing one half of the size word leaves the other half unchanged.
- R4: A write to window 1's size register replaces the whole 64-bit size word, with the upper 32 bits set to zero. The register reads back the written value.
- R5: Bit 0 of a window's size word enables that window. A window with bit 0 clear never hits.
- R6: A window's span is the 64-bit two's complement of its size word with bits 2:0 cleared. An address hits when it is below the span. A span of zero never hits.
- R7: On a hit, the output address is the window's local base plus the input address, taken modulo 2^64.
- R8: When several windows hit, the lowest-numbered window wins. Its index is reported on `xl_win`.
- R9: While `bm_claimed` is high, no window hits and the address passes through unchanged.
- R10: On a miss, `xl_hit` is 0 and `xl_addr` equals the input address.
- R11: Each `bm_valid` cycle yields exactly one `xl_valid` cycle one clock later. Back-to-back lookups are accepted on consecutive cycles.
- R12: The status word at 0xE0 is readable and writable as a full 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe; data appears on cfg_rdata next cycle |
| cfg_ofs | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| bm_valid | input | 1 | Bus-master address valid |
| bm_addr | input | 64 | Bus-master address |
| bm_claimed | input | 1 | Address belongs to the direct bus-memory view |
| xl_valid | output | 1 | Lookup result valid |
| xl_hit | output | 1 | An inbound window matched |
| xl_win | output | 2 | Index of the matching window (0 on a miss) |
| xl_addr | output | 64 | Translated local address, or the input address on a miss |

## Verification
The hardest situations to reach are the interactions between windows. These include overlapping windows where priority decides the result, a window whose span wraps to zero, and a local base near the top of the 64-bit space where the sum overflows. To reach them, the stimulus first opens a very large window 1 over a smaller window 0, then disables the lower windows one by one to expose the others. It then clears the high size half of window 0 to force a zero span while window 2 still covers the same address. Window 2's base is placed so that the translated address wraps past 2^64.

// File: rtl/inb_xlate_pkg.sv
// Package: shared widths, register offsets and window configuration type
// for the inbound DMA window translator.
package inb_xlate_pkg;

    localparam int NWIN   = 3;
    localparam int ADDR_W = 64;
    localparam int REG_W  = 32;
    localparam int OFS_W  = 8;
    localparam int IDX_W  = $clog2(NWIN);
    localparam int IGN_LO = 3;   // low size-word bits ignored for the span

    localparam logic [ADDR_W-1:0] ATTR_RST = {{REG_W{1'b1}}, {REG_W{1'b0}}};

    // Register offsets; software depends on these positions.
    localparam logic [OFS_W-1:0] OFS_W0_SZ_LO = 8'h98;
    localparam logic [OFS_W-1:0] OFS_W0_LB_LO = 8'h9C;
    localparam logic [OFS_W-1:0] OFS_W0_LB_HI = 8'hA0;
    localparam logic [OFS_W-1:0] OFS_W1_SZ    = 8'hA4;
    localparam logic [OFS_W-1:0] OFS_W1_LB_LO = 8'hA8;
    localparam logic [OFS_W-1:0] OFS_W1_LB_HI = 8'hAC;
    localparam logic [OFS_W-1:0] OFS_W2_SZ_LO = 8'hB0;
    localparam logic [OFS_W-1:0] OFS_W2_LB_LO = 8'hB4;
    localparam logic [OFS_W-1:0] OFS_W2_LB_HI = 8'hB8;
    localparam logic [OFS_W-1:0] OFS_STATUS   = 8'hE0;
    localparam logic [OFS_W-1:0] OFS_W0_SZ_HI = 8'hF8;
    localparam logic [OFS_W-1:0] OFS_W2_SZ_HI = 8'hFC;

    typedef struct packed {
        logic [ADDR_W-1:0] attr;   // size/attribute word, bit 0 = enable
        logic [ADDR_W-1:0] base;   // local base address
    } win_cfg_t;

endpackage

// File: rtl/inb_cfg_regs.sv
// Module: inb_cfg_regs
// Holds the window configuration and the status word. Software reaches them
// through a 32-bit offset-addressed port. Reads are registered (one-cycle
// latency). Assumes the write and read strobes are single-cycle pulses and
// that a write and a read to the same offset do not coincide.
module inb_cfg_regs
    import inb_xlate_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic                    rd_en_i,
    input  logic [OFS_W-1:0]        ofs_i,
    input  logic [REG_W-1:0]        wdata_i,
    output logic [REG_W-1:0]        rdata_o,
    output win_cfg_t [NWIN-1:0]     cfg_o
);

    win_cfg_t [NWIN-1:0] cfg_q;
    logic [REG_W-1:0]    sts_q;
    logic [REG_W-1:0]    rd_mux;

    // Register storage: reset values, then half-word or whole-word updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWIN; w++) begin
                cfg_q[w].attr <= ATTR_RST;
                cfg_q[w].base <= '0;
            end
            sts_q <= '0;
        end else if (wr_en_i) begin
            case (ofs_i)
                OFS_W0_SZ_LO: cfg_q[0].attr[REG_W-1:0]      <= wdata_i;
                OFS_W0_SZ_HI: cfg_q[0].attr[ADDR_W-1:REG_W] <= wdata_i;
                OFS_W0_LB_LO: cfg_q[0].base[REG_W-1:0]      <= wdata_i;
                OFS_W0_LB_HI: cfg_q[0].base[ADDR_W-1:REG_W] <= wdata_i;
                OFS_W1_SZ:    cfg_q[1].attr                 <= {{(ADDR_W-REG_W){1'b0}}, wdata_i};
                OFS_W1_LB_LO: cfg_q[1].base[REG_W-1:0]      <= wdata_i;
                OFS_W1_LB_HI: cfg_q[1].base[ADDR_W-1:REG_W] <= wdata_i;
                OFS_W2_SZ_LO: cfg_q[2].attr[REG_W-1:0]      <= wdata_i;
                OFS_W2_SZ_HI: cfg_q[2].attr[ADDR_W-1:REG_W] <= wdata_i;
                OFS_W2_LB_LO: cfg_q[2].base[REG_W-1:0]      <= wdata_i;
                OFS_W2_LB_HI: cfg_q[2].base[ADDR_W-1:REG_W] <= wdata_i;
                OFS_STATUS:   sts_q                         <= wdata_i;
                default: ;
            endcase
        end
    end

    // Read decode: unmapped offsets read as zero.
    always_comb begin
        case (ofs_i)
            OFS_W0_SZ_LO: rd_mux = cfg_q[0].attr[REG_W-1:0];
            OFS_W0_SZ_HI: rd_mux = cfg_q[0].attr[ADDR_W-1:REG_W];
            OFS_W0_LB_LO: rd_mux = cfg_q[0].base[REG_W-1:0];
            OFS_W0_LB_HI: rd_mux = cfg_q[0].base[ADDR_W-1:REG_W];
            OFS_W1_SZ:    rd_mux = cfg_q[1].attr[REG_W-1:0];
            OFS_W1_LB_LO: rd_mux = cfg_q[1].base[REG_W-1:0];
            OFS_W1_LB_HI: rd_mux = cfg_q[1].base[ADDR_W-1:REG_W];
            OFS_W2_SZ_LO: rd_mux = cfg_q[2].attr[REG_W-1:0];
            OFS_W2_SZ_HI: rd_mux = cfg_q[2].attr[ADDR_W-1:REG_W];
            OFS_W2_LB_LO: rd_mux = cfg_q[2].base[REG_W-1:0];
            OFS_W2_LB_HI: rd_mux = cfg_q[2].base[ADDR_W-1:REG_W];
            OFS_STATUS:   rd_mux = sts_q;
            default:      rd_mux = '0;
        endcase
    end

    // Read data register: captures the decoded word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_mux;
    end

    assign cfg_o = cfg_q;

    // R4: the single size write of window 1 leaves its upper half zero.
    p_w1_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ofs_i == OFS_W1_SZ) |=> cfg_q[1].attr[ADDR_W-1:REG_W] == '0);

    // R12: a status write is held exactly.
    p_status_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ofs_i == OFS_STATUS) |=> sts_q == $past(wdata_i));

    // R3: a low-half size write of window 0 keeps the high half.
    p_w0_hi_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ofs_i == OFS_W0_SZ_LO) |=>
        cfg_q[0].attr[ADDR_W-1:REG_W] == $past(cfg_q[0].attr[ADDR_W-1:REG_W]));

endmodule

// File: rtl/inb_win_match.sv
// Module: inb_win_match
// Decides whether one window covers an address and forms the rebased
// address. Assumes the window is based at bus address zero. The span is
// the two's complement of the size word with its low bits masked. A zero
// span covers nothing.
module inb_win_match
    import inb_xlate_pkg::*;
(
    input  win_cfg_t            cfg_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                hit_o,
    output logic [ADDR_W-1:0]   xaddr_o
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << IGN_LO) - 1);

    logic [ADDR_W-1:0] span;

    // Span decode and comparison for this window.
    always_comb begin
        span    = ~(cfg_i.attr & ~LOW_MASK) + ADDR_W'(1);
        hit_o   = cfg_i.attr[0] && (addr_i < span);
        xaddr_o = cfg_i.base + addr_i;
    end

endmodule

// File: rtl/inb_win_pick.sv
// Module: inb_win_pick
// Fixed-priority selection among window matches (lowest index wins).
// Applies the bus-memory claim, which overrides every window. Assumes
// hit and address vectors are index-aligned.
module inb_win_pick
    import inb_xlate_pkg::*;
(
    input  logic [NWIN-1:0]                 hit_i,
    input  logic [NWIN-1:0][ADDR_W-1:0]     xaddr_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic                            claimed_i,
    output logic                            hit_o,
    output logic [IDX_W-1:0]                idx_o,
    output logic [ADDR_W-1:0]               addr_o
);

    // Priority scan from the top so the lowest matching index is kept last.
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        addr_o = addr_i;
        if (!claimed_i) begin
            for (int i = NWIN - 1; i >= 0; i--) begin
                if (hit_i[i]) begin
                    hit_o  = 1'b1;
                    idx_o  = IDX_W'(i);
                    addr_o = xaddr_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/inb_dma_xlate.sv
// Module: inb_dma_xlate (top)
// Inbound DMA window translator. It holds the configuration registers and
// one matcher per window, and picks a window by fixed priority. The result
// is registered one cycle after each valid bus-master address. Assumes
// configuration is not rewritten in the same cycle as a lookup that
// depends on it.
module inb_dma_xlate
    import inb_xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_rd,
    input  logic [7:0]          cfg_ofs,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                bm_valid,
    input  logic [63:0]         bm_addr,
    input  logic                bm_claimed,
    output logic                xl_valid,
    output logic                xl_hit,
    output logic [1:0]          xl_win,
    output logic [63:0]         xl_addr
);

    win_cfg_t [NWIN-1:0]             cfg;
    logic [NWIN-1:0]                 win_hit;
    logic [NWIN-1:0][ADDR_W-1:0]     win_xaddr;
    logic [NWIN-1:0]                 win_en;
    logic                            sel_hit;
    logic [IDX_W-1:0]                sel_idx;
    logic [ADDR_W-1:0]               sel_addr;

    inb_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (cfg_wr),
        .rd_en_i (cfg_rd),
        .ofs_i   (cfg_ofs),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .cfg_o   (cfg)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        inb_win_match u_match (
            .cfg_i   (cfg[g]),
            .addr_i  (bm_addr),
            .hit_o   (win_hit[g]),
            .xaddr_o (win_xaddr[g])
        );
        assign win_en[g] = cfg[g].attr[0];
    end

    inb_win_pick u_pick (
        .hit_i     (win_hit),
        .xaddr_i   (win_xaddr),
        .addr_i    (bm_addr),
        .claimed_i (bm_claimed),
        .hit_o     (sel_hit),
        .idx_o     (sel_idx),
        .addr_o    (sel_addr)
    );

    // Result stage: one registered cycle per valid lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid <= 1'b0;
            xl_hit   <= 1'b0;
            xl_win   <= '0;
            xl_addr  <= '0;
        end else begin
            xl_valid <= bm_valid;
            if (bm_valid) begin
                xl_hit  <= sel_hit;
                xl_win  <= sel_idx;
                xl_addr <= sel_addr;
            end
        end
    end

    // R11: each valid input produces a result one cycle later.
    p_result_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bm_valid |=> xl_valid);
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bm_valid |=> !xl_valid);

    // R9: a claimed address is never redirected.
    p_claim_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_valid && bm_claimed) |=> !xl_hit);

    // R10: a miss returns the input address unchanged.
    p_miss_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bm_valid |=> (xl_hit || xl_addr == $past(bm_addr)));

    // R5: a reported window was enabled when the lookup was taken.
    p_hit_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_hit) |-> |($past(win_en) & (NWIN'(1) << xl_win)));

    // R8: the reported index names an existing window.
    p_win_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_hit) |-> (xl_win < IDX_W'(NWIN)));

endmodule

// File: tb/tb_inb_dma_xlate.sv
module tb_inb_dma_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_ofs = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bm_valid = 1'b0;
    logic [63:0] bm_addr = '0;
    logic        bm_claimed = 1'b0;
    logic        xl_valid;
    logic        xl_hit;
    logic [1:0]  xl_win;
    logic [63:0] xl_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        bit          hit;
        logic [1:0]  win;
        logic [63:0] addr;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    inb_dma_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_ofs(cfg_ofs),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bm_valid(bm_valid), .bm_addr(bm_addr), .bm_claimed(bm_claimed),
        .xl_valid(xl_valid), .xl_hit(xl_hit), .xl_win(xl_win), .xl_addr(xl_addr)
    );

    task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_ofs = ofs; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] ofs, input logic [31:0] exp, input string tag);
        cfg_rd = 1'b1; cfg_ofs = ofs;
        @(negedge clk);
        cfg_rd = 1'b0;
        n_cmp++;
        if (cfg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: ofs %h read %h expected %h", tag, ofs, cfg_rdata, exp);
        end
    endtask

    // Driver: push the expected result, then present the address for one cycle.
    task automatic lk(input logic [63:0] a, input bit claim, input bit eh,
                      input logic [1:0] ew, input logic [63:0] ea, input string tag);
        exp_t e;
        e.hit = eh; e.win = ew; e.addr = ea; e.tag = tag;
        sb.push_back(e);
        bm_valid = 1'b1; bm_addr = a; bm_claimed = claim;
        @(negedge clk);
        bm_valid = 1'b0; bm_claimed = 1'b0;
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && xl_valid) begin
            n_cmp++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R11: unexpected result hit=%0d addr=%h expected none", xl_hit, xl_addr);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (xl_hit !== e.hit || xl_addr !== e.addr || (e.hit && xl_win !== e.win)) begin
                    n_bad++;
                    $display("FAIL %s: hit=%0d win=%0d addr=%h expected hit=%0d win=%0d addr=%h",
                             e.tag, xl_hit, xl_win, xl_addr, e.hit, e.win, e.addr);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd_chk(8'h98, 32'h0000_0000, "R1 w0 size lo");
        rd_chk(8'hF8, 32'hFFFF_FFFF, "R1 w0 size hi");
        rd_chk(8'hA4, 32'h0000_0000, "R1 w1 size");
        rd_chk(8'hFC, 32'hFFFF_FFFF, "R1 w2 size hi");
        rd_chk(8'h9C, 32'h0, "R1 w0 base lo");
        rd_chk(8'hAC, 32'h0, "R1 w1 base hi");
        rd_chk(8'hB8, 32'h0, "R1 w2 base hi");
        rd_chk(8'hE0, 32'h0, "R1 status");
        lk(64'h1000, 0, 0, 0, 64'h1000, "R1 reset miss");
        lk(64'h0, 0, 0, 0, 64'h0, "R10 reset miss zero");

        // R2: unmapped offsets
        wr(8'h00, 32'hDEAD_BEEF);
        rd_chk(8'h00, 32'h0, "R2 unmapped 0x00");
        wr(8'h94, 32'h1234_5678);
        rd_chk(8'h94, 32'h0, "R2 unmapped 0x94");

        // Window 0: base 0x1_2000_0000, span 0x1000_0000
        wr(8'h9C, 32'h2000_0000);
        wr(8'hA0, 32'h0000_0001);
        wr(8'h98, 32'hF000_0001);
        rd_chk(8'hF8, 32'hFFFF_FFFF, "R3 w0 hi kept");
        lk(64'h0, 0, 1, 0, 64'h1_2000_0000, "R7 w0 base");
        lk(64'h0FFF_FFFF, 0, 1, 0, 64'h1_2FFF_FFFF, "R6 w0 last");
        lk(64'h1000_0000, 0, 0, 0, 64'h1000_0000, "R6 w0 edge miss");
        wr(8'h98, 32'hF000_0007);
        lk(64'h0FFF_FFF8, 0, 1, 0, 64'h1_2FFF_FFF8, "R6 low bits ignored");
        lk(64'h1000_0000, 0, 0, 0, 64'h1000_0000, "R6 low bits edge");

        // Window 1: whole-word size, huge span
        wr(8'hA8, 32'h4000_0000);
        wr(8'hAC, 32'h0);
        wr(8'hA4, 32'hFFFF_0001);
        rd_chk(8'hA4, 32'hFFFF_0001, "R4 w1 size read");
        lk(64'h2000_0000, 0, 1, 1, 64'h6000_0000, "R4 w1 hit");
        lk(64'h100, 0, 1, 0, 64'h1_2000_0100, "R8 priority w0");
        lk(64'hFFFF_FFFF_0001_0000, 0, 0, 0, 64'hFFFF_FFFF_0001_0000, "R4 w1 edge");

        // R5: disable window 0
        wr(8'h98, 32'hF000_0000);
        lk(64'h100, 0, 1, 1, 64'h4000_0100, "R5 w0 disabled");

        // R9: claimed addresses pass through
        lk(64'h100, 1, 0, 0, 64'h100, "R9 claimed");

        // Window 2: split halves and wrap
        wr(8'hB0, 32'hFFFF_F001);
        rd_chk(8'hB0, 32'hFFFF_F001, "R3 w2 lo");
        wr(8'hFC, 32'h1234_5678);
        rd_chk(8'hB0, 32'hFFFF_F001, "R3 w2 lo kept");
        rd_chk(8'hFC, 32'h1234_5678, "R3 w2 hi");
        wr(8'hFC, 32'hFFFF_FFFF);
        wr(8'hB4, 32'hFFFF_FF00);
        wr(8'hB8, 32'hFFFF_FFFF);
        wr(8'hA4, 32'h0);
        lk(64'h200, 0, 1, 2, 64'h100, "R7 w2 wrap");
        lk(64'h1000, 0, 0, 0, 64'h1000, "R6 w2 edge");

        // R6: zero span on window 0 while window 2 covers the address
        wr(8'hF8, 32'h0);
        wr(8'h98, 32'h0000_0001);
        lk(64'h0, 0, 1, 2, 64'hFFFF_FFFF_FFFF_FF00, "R6 zero span");

        // R11: back-to-back lookups
        lk(64'h10, 0, 1, 2, 64'hFFFF_FFFF_FFFF_FF10, "R11 b2b 0");
        lk(64'h10, 1, 0, 0, 64'h10, "R11 b2b 1");
        lk(64'h2000, 0, 0, 0, 64'h2000, "R11 b2b 2");

        // R12: status
        wr(8'hE0, 32'hA5A5_0F0F);
        rd_chk(8'hE0, 32'hA5A5_0F0F, "R12 status");

        repeat (3) @(negedge clk);
        n_cmp++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R11: %0d results outstanding expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule